// File: doc/BRIEF.md
# Counter-Hypothesis List Manager for Single-Search Soft Detection

This block keeps the per-symbol candidate list for a soft-output MIMO detector that searches its tree once. For each symbol it holds the best bit label found so far, the metric of that label, and one counter-hypothesis metric per label bit. The counter-hypothesis metric of a bit is the best metric seen among labels whose value in that bit is the opposite of the best label's value. The tree search hands over every leaf it reaches as a bit label plus an unsigned metric. The block updates the list from each leaf in one cycle. After each change of the best label it limits the counter-hypothesis metrics to a run-time bound above the best metric.

When asked to finalize a symbol, the block returns the best label, its metric and one signed max-log LLR per bit. The sign of each LLR comes from the best label's bit. Several list contexts are kept side by side, so that symbols interleaved through a pipelined search never share state. Setting the bound to zero turns the block into a hard-output detector: every LLR is zero.

Top module: `chl_list_mgr`

## Requirements
- R1: After reset, and after a start pulse (`startValid`) on a context, that context holds best metric 16'hFFFF (infinity), best label 0 and every counter-hypothesis metric at infinity.
- R2: A leaf whose metric d is strictly below the best metric becomes the new best. Each counter-hypothesis whose leaf bit differs from the stored best bit first takes the old best metric. Then the best metric becomes d and the best label becomes the leaf label.
- R3: A leaf with d greater than or equal to the best metric leaves the best label and metric unchanged. A counter-hypothesis takes d only when its leaf bit differs from the best bit and d is below its current value.
- R4: Only after a new-best update, every counter-hypothesis metric becomes the minimum of itself and (best metric + `lmax`). That sum saturates at 16'hFFFF instead of wrapping.
- R5: The LLR for bit b is (best − counter) when best bit b is 0, and (counter − best) when it is 1. It is a 17-bit two's-complement value at `outLlr[b*17 +: 17]`. Label bit b is `leafLabel[b]` / `outLabel[b]`.
- R6: A counter-hypothesis still at 16'hFFFF when the context is finalized gives magnitude 65535: −65535 for best bit 0, +65535 for best bit 1.
- R7: With `lmax` = 0 during all updates of a symbol that saw at least one leaf, every LLR output is 0, and the best label and metric are still returned.
- R8: Each context keeps its own list. Leaves, starts and finalizes on one context do not change another context.
- R9: `leafReady` is low while `startValid` or `finValid` is high. A leaf offered then is not taken and has no effect on the list.
- R10: A finalize request (`finValid`, `finCtx`) gives `outValid` high for exactly one cycle, one cycle later, with `outCtx` equal to the requested context. `outLabel`, `outMetric` and `outLlr` hold that context's list as it stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lmax | input | 16 | Clipping bound added to the best metric |
| startValid | input | 1 | Reset one context to infinity |
| startCtx | input | 1 | Context to reset |
| leafValid | input | 1 | Leaf offered |
| leafReady | output | 1 | Leaf can be taken this cycle |
| leafCtx | input | 1 | Context of the leaf |
| leafLabel | input | 24 | Leaf bit label |
| leafMetric | input | 16 | Leaf metric |
| finValid | input | 1 | Finalize request |
| finCtx | input | 1 | Context to finalize |
| outValid | output | 1 | Finalized result valid |
| outCtx | output | 1 | Context of the result |
| outLabel | output | 24 | Best label |
| outMetric | output | 16 | Best metric |
| outLlr | output | 408 | 24 signed 17-bit LLRs |

## Verification
The bench aims at leaves whose metric equals the best metric. A design that treats them as a new best would flip the label and move the counter metrics. It also covers the saturating bound: a bound close to infinity that wraps would clip the counters below the best metric and flip LLR signs. Counters never reached must come out at full magnitude with the right sign, and a bound of zero must give all-zero LLRs. Leaves offered during a start or finalize, and leaves that alternate between contexts, show whether state leaks between symbols or a blocked leaf is taken anyway.

// File: rtl/chl_pkg.sv
package chl_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic initEn;
    logic updEn;
    logic finEn;
  } ctrlStrobe_t;

endpackage

// File: rtl/chl_ctrl.sv
module chl_ctrl
  import chl_pkg::*;
#(
  parameter int CTX_W = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startValid,
  input  logic             leafValid,
  input  logic             finValid,
  input  logic [CTX_W-1:0] finCtx,
  output logic             leafReady,
  output ctrlStrobe_t      stb,
  output logic             outValid,
  output logic [CTX_W-1:0] outCtx
);

  // Start and finalize own the list port for their cycle
  assign leafReady  = !(startValid || finValid);
  assign stb.initEn = startValid;
  assign stb.updEn  = leafValid && leafReady;
  assign stb.finEn  = finValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outCtx   <= '0;
    end else begin
      outValid <= finValid;
      if (finValid) outCtx <= finCtx;
    end
  end

endmodule

// File: rtl/chl_datapath.sv
module chl_datapath
  import chl_pkg::*;
#(
  parameter int NB      = 24,
  parameter int MW      = 16,
  parameter int NUM_CTX = 2,
  parameter int CTX_W   = 1,
  parameter int LW      = 17
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      stb,
  input  logic [MW-1:0]    lmax,
  input  logic [CTX_W-1:0] startCtx,
  input  logic [CTX_W-1:0] leafCtx,
  input  logic [NB-1:0]    leafLabel,
  input  logic [MW-1:0]    leafMetric,
  input  logic [CTX_W-1:0] finCtx,
  output logic [NB-1:0]    outLabel,
  output logic [MW-1:0]    outMetric,
  output logic [NB*LW-1:0] outLlr
);

  localparam logic [MW-1:0] INF = '1;

  function automatic logic [MW-1:0] satAdd(input logic [MW-1:0] a, input logic [MW-1:0] b);
    logic [MW:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[MW] ? INF : s[MW-1:0];
  endfunction

  logic [MW-1:0]    mlMet [NUM_CTX];
  logic [NB-1:0]    mlLab [NUM_CTX];
  logic [NB*MW-1:0] cMet  [NUM_CTX];

  // Update-side view of the selected context
  logic [MW-1:0]    curMl;
  logic [NB-1:0]    curLab;
  logic [NB*MW-1:0] curC;
  logic [NB*MW-1:0] newC;
  logic             isNewMl;
  logic [MW-1:0]    clipVal;

  assign curMl   = mlMet[leafCtx];
  assign curLab  = mlLab[leafCtx];
  assign curC    = cMet[leafCtx];
  assign isNewMl = leafMetric < curMl;
  assign clipVal = satAdd(leafMetric, lmax);

  // Finalize-side view
  logic [MW-1:0]    finMl;
  logic [NB-1:0]    finLab;
  logic [NB*MW-1:0] finC;
  logic [NB*LW-1:0] llrNext;

  assign finMl  = mlMet[finCtx];
  assign finLab = mlLab[finCtx];
  assign finC   = cMet[finCtx];

  for (genvar b = 0; b < NB; b++) begin : gBit
    logic          diff;
    logic [MW-1:0] oldC;
    logic [MW-1:0] handoff;
    logic [MW-1:0] fc;
    logic [MW-1:0] mag;

    assign diff    = leafLabel[b] ^ curLab[b];
    assign oldC    = curC[b*MW +: MW];
    assign handoff = diff ? curMl : oldC;
    assign newC[b*MW +: MW] = isNewMl
                            ? ((handoff < clipVal) ? handoff : clipVal)
                            : ((diff && (leafMetric < oldC)) ? leafMetric : oldC);

    assign fc  = finC[b*MW +: MW];
    assign mag = (fc == INF) ? INF : (fc - finMl);
    assign llrNext[b*LW +: LW] = finLab[b] ? {1'b0, mag} : (LW'(0) - {1'b0, mag});
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CTX; c++) begin
        mlMet[c] <= INF;
        mlLab[c] <= '0;
        cMet[c]  <= '1;
      end
      outLabel  <= '0;
      outMetric <= '0;
      outLlr    <= '0;
    end else begin
      if (stb.initEn) begin
        mlMet[startCtx] <= INF;
        mlLab[startCtx] <= '0;
        cMet[startCtx]  <= '1;
      end
      if (stb.updEn) begin
        cMet[leafCtx] <= newC;
        if (isNewMl) begin
          mlMet[leafCtx] <= leafMetric;
          mlLab[leafCtx] <= leafLabel;
        end
      end
      if (stb.finEn) begin
        outLabel  <= finLab;
        outMetric <= finMl;
        outLlr    <= llrNext;
      end
    end
  end

endmodule

// File: rtl/chl_list_mgr.sv
module chl_list_mgr
  import chl_pkg::*;
#(
  parameter int NUM_STREAMS  = 4,
  parameter int BITS_PER_SYM = 6,
  parameter int METRIC_W     = 16,
  parameter int NUM_CTX      = 2
) (
  input  logic                                     clk,
  input  logic                                     rstN,
  input  logic [METRIC_W-1:0]                      lmax,
  input  logic                                     startValid,
  input  logic [((NUM_CTX>1)?$clog2(NUM_CTX):1)-1:0] startCtx,
  input  logic                                     leafValid,
  output logic                                     leafReady,
  input  logic [((NUM_CTX>1)?$clog2(NUM_CTX):1)-1:0] leafCtx,
  input  logic [NUM_STREAMS*BITS_PER_SYM-1:0]      leafLabel,
  input  logic [METRIC_W-1:0]                      leafMetric,
  input  logic                                     finValid,
  input  logic [((NUM_CTX>1)?$clog2(NUM_CTX):1)-1:0] finCtx,
  output logic                                     outValid,
  output logic [((NUM_CTX>1)?$clog2(NUM_CTX):1)-1:0] outCtx,
  output logic [NUM_STREAMS*BITS_PER_SYM-1:0]      outLabel,
  output logic [METRIC_W-1:0]                      outMetric,
  output logic [NUM_STREAMS*BITS_PER_SYM*(METRIC_W+1)-1:0] outLlr
);

  localparam int NB    = NUM_STREAMS * BITS_PER_SYM;
  localparam int LW    = METRIC_W + 1;
  localparam int CTX_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;

  ctrlStrobe_t stb;

  chl_ctrl #(.CTX_W(CTX_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .startValid(startValid), .leafValid(leafValid),
    .finValid(finValid), .finCtx(finCtx),
    .leafReady(leafReady), .stb(stb),
    .outValid(outValid), .outCtx(outCtx)
  );

  chl_datapath #(.NB(NB), .MW(METRIC_W), .NUM_CTX(NUM_CTX), .CTX_W(CTX_W), .LW(LW)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .lmax(lmax),
    .startCtx(startCtx), .leafCtx(leafCtx),
    .leafLabel(leafLabel), .leafMetric(leafMetric),
    .finCtx(finCtx),
    .outLabel(outLabel), .outMetric(outMetric), .outLlr(outLlr)
  );

endmodule

// File: rtl/chl_list_chk.sv
module chl_list_chk #(
  parameter int NB    = 24,
  parameter int LW    = 17,
  parameter int CTX_W = 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             startValid,
  input logic             leafValid,
  input logic             leafReady,
  input logic             finValid,
  input logic [CTX_W-1:0] finCtx,
  input logic             outValid,
  input logic [CTX_W-1:0] outCtx,
  input logic [NB-1:0]    outLabel,
  input logic [NB*LW-1:0] outLlr
);

  // R9
  no_leaf_during_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (leafValid && leafReady) |-> !startValid);

  // R10
  out_follows_fin_chk: assert property (@(posedge clk) disable iff (!rstN)
    finValid |=> outValid);

  // R10
  out_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !finValid |=> !outValid);

  // R10
  out_ctx_echo_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outCtx == $past(finCtx)));

  for (genvar b = 0; b < NB; b++) begin : gSign
    // R5
    llr_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
      outValid |-> (outLabel[b] ? !outLlr[b*LW+LW-1]
                                : (outLlr[b*LW+LW-1] || (outLlr[b*LW +: LW] == '0))));
  end

endmodule

bind chl_list_mgr chl_list_chk #(.NB(NB), .LW(LW), .CTX_W(CTX_W)) uChk (
  .clk(clk), .rstN(rstN), .startValid(startValid), .leafValid(leafValid),
  .leafReady(leafReady), .finValid(finValid), .finCtx(finCtx),
  .outValid(outValid), .outCtx(outCtx), .outLabel(outLabel), .outLlr(outLlr)
);

// File: tb/sim_chl_list_mgr.sv
`timescale 1ns/1ps
module sim_chl_list_mgr;

  localparam int NB = 24;
  localparam int MW = 16;
  localparam int LW = 17;
  localparam logic [15:0] INF = 16'hFFFF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] lmax = INF;
  logic startValid = 1'b0, startCtx = 1'b0;
  logic leafValid = 1'b0, leafCtx = 1'b0;
  logic leafReady;
  logic [NB-1:0] leafLabel = '0;
  logic [15:0] leafMetric = '0;
  logic finValid = 1'b0, finCtx = 1'b0;
  logic outValid, outCtx;
  logic [NB-1:0] outLabel;
  logic [15:0] outMetric;
  logic [NB*LW-1:0] outLlr;

  always #2.5 clk = ~clk;

  chl_list_mgr u0 (
    .clk(clk), .rstN(rstN), .lmax(lmax),
    .startValid(startValid), .startCtx(startCtx),
    .leafValid(leafValid), .leafReady(leafReady), .leafCtx(leafCtx),
    .leafLabel(leafLabel), .leafMetric(leafMetric),
    .finValid(finValid), .finCtx(finCtx),
    .outValid(outValid), .outCtx(outCtx), .outLabel(outLabel),
    .outMetric(outMetric), .outLlr(outLlr)
  );

  int nChecks = 0;
  int nFails = 0;

  // Expected list state per context
  logic [15:0]   mMl  [2];
  logic [NB-1:0] mLab [2];
  logic [15:0]   mC   [2][NB];

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] satAdd(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[16] ? INF : s[15:0];
  endfunction

  function automatic logic [16:0] expLlr(input logic [15:0] ml, input logic [15:0] c, input logic bitv);
    logic [15:0] mag;
    mag = (c == INF) ? INF : (c - ml);
    return bitv ? {1'b0, mag} : (17'd0 - {1'b0, mag});
  endfunction

  task automatic mdlClear(input int c);
    mMl[c] = INF;
    mLab[c] = '0;
    for (int b = 0; b < NB; b++) mC[c][b] = INF;
  endtask

  task automatic mdlLeaf(input int c, input logic [NB-1:0] lab, input logic [15:0] m);
    logic [15:0] t;
    logic [15:0] clip;
    if (m < mMl[c]) begin
      clip = satAdd(m, lmax);
      for (int b = 0; b < NB; b++) begin
        t = (lab[b] != mLab[c][b]) ? mMl[c] : mC[c][b];
        mC[c][b] = (t < clip) ? t : clip;
      end
      mMl[c] = m;
      mLab[c] = lab;
    end else begin
      for (int b = 0; b < NB; b++)
        if ((lab[b] != mLab[c][b]) && (m < mC[c][b])) mC[c][b] = m;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    leafValid = 1'b0;
    startValid = 1'b0;
    finValid = 1'b0;
  endtask

  task automatic doStart(input logic c);
    @(negedge clk);
    leafValid = 1'b0;
    startValid = 1'b1;
    startCtx = c;
    @(posedge clk);
    mdlClear(int'(c));
    @(negedge clk);
    startValid = 1'b0;
  endtask

  task automatic doLeaf(input logic c, input logic [NB-1:0] lab, input logic [15:0] m);
    @(negedge clk);
    leafValid = 1'b1;
    leafCtx = c;
    leafLabel = lab;
    leafMetric = m;
    #1;
    check(leafReady == 1'b1, "R9 ready when idle", 64'(leafReady), 64'd1);
    @(posedge clk);
    mdlLeaf(int'(c), lab, m);
  endtask

  // Finalize a context and compare the whole list with the expected state
  task automatic doFin(input logic c, input string tag);
    @(negedge clk);
    leafValid = 1'b0;
    finValid = 1'b1;
    finCtx = c;
    @(negedge clk);
    finValid = 1'b0;
    check(outValid == 1'b1, "R10 outValid", 64'(outValid), 64'd1);
    check(outCtx == c, "R10 outCtx", 64'(outCtx), 64'(c));
    check(outMetric == mMl[int'(c)], {tag, " metric"}, 64'(outMetric), 64'(mMl[int'(c)]));
    check(outLabel == mLab[int'(c)], {tag, " label"}, 64'(outLabel), 64'(mLab[int'(c)]));
    for (int b = 0; b < NB; b++) begin
      logic [16:0] e;
      e = expLlr(mMl[int'(c)], mC[int'(c)][b], mLab[int'(c)][b]);
      check(outLlr[b*LW +: LW] == e, {tag, " llr"}, 64'(outLlr[b*LW +: LW]), 64'(e));
    end
    @(negedge clk);
    check(outValid == 1'b0, "R10 single pulse", 64'(outValid), 64'd0);
  endtask

  function automatic logic [16:0] llrAt(input int b);
    return outLlr[b*LW +: LW];
  endfunction

  task automatic tReset();
    mdlClear(0);
    mdlClear(1);
    doFin(1'b0, "R1 reset");
    doFin(1'b1, "R6 reset infinity");
  endtask

  task automatic tBasic();
    lmax = INF;
    doStart(1'b0);
    doLeaf(1'b0, 24'h000003, 16'd100);
    doLeaf(1'b0, 24'h000005, 16'd80);   // R2 new best
    doLeaf(1'b0, 24'h000006, 16'd90);   // R3 counter only
    doLeaf(1'b0, 24'h800005, 16'd80);   // R3 equal metric is not a new best
    doFin(1'b0, "R2 R3 R5 basic");
    check(outMetric == 16'd80, "R2 best metric", 64'(outMetric), 64'd80);
    check(outLabel == 24'h000005, "R3 equal leaf kept label", 64'(outLabel), 64'h5);
    // bit1: best bit 0, counter 90 from third leaf? bit1 of 6 is 1 vs 0 -> -(90-80)
    check(llrAt(1) == 17'h1FFF6, "R5 bit1", 64'(llrAt(1)), 64'h1FFF6);
    // bit23: counter 80 from the equal leaf -> 0
    check(llrAt(23) == 17'd0, "R3 equal leaf counter", 64'(llrAt(23)), 64'd0);
  endtask

  task automatic tClip();
    lmax = 16'd15;
    doStart(1'b0);
    doLeaf(1'b0, 24'h00000F, 16'd200);
    doLeaf(1'b0, 24'h0000F0, 16'd50);
    doFin(1'b0, "R4 clip");
    check(llrAt(4) == 17'd15, "R4 clipped positive", 64'(llrAt(4)), 64'd15);
    check(llrAt(0) == 17'h1FFF1, "R4 clipped negative", 64'(llrAt(0)), 64'h1FFF1);
    // Saturating bound
    lmax = 16'hFFF0;
    doStart(1'b1);
    doLeaf(1'b1, 24'h000001, 16'd100);
    doFin(1'b1, "R4 saturating add");
    check(llrAt(0) == 17'd65535, "R6 bit0 positive", 64'(llrAt(0)), 64'd65535);
    check(llrAt(1) == 17'h10001, "R6 bit1 negative", 64'(llrAt(1)), 64'h10001);
  endtask

  task automatic tHard();
    lmax = 16'd0;
    doStart(1'b0);
    doLeaf(1'b0, 24'hABCDEF, 16'd500);
    doLeaf(1'b0, 24'h123456, 16'd300);
    doLeaf(1'b0, 24'hFFFFFF, 16'd310);
    doLeaf(1'b0, 24'h000000, 16'd200);
    doFin(1'b0, "R7 hard");
    for (int b = 0; b < NB; b++)
      check(llrAt(b) == 17'd0, "R7 zero llr", 64'(llrAt(b)), 64'd0);
    check(outMetric == 16'd200, "R7 best metric", 64'(outMetric), 64'd200);
  endtask

  task automatic tContexts();
    lmax = 16'd40;
    doStart(1'b0);
    doStart(1'b1);
    doLeaf(1'b0, 24'h111111, 16'd400);
    doLeaf(1'b1, 24'h222222, 16'd100);
    doLeaf(1'b0, 24'h333333, 16'd350);
    doLeaf(1'b1, 24'h444444, 16'd120);
    doLeaf(1'b0, 24'h555555, 16'd380);
    doLeaf(1'b1, 24'h666666, 16'd90);
    doFin(1'b0, "R8 ctx0");
    doFin(1'b1, "R8 ctx1");
    doStart(1'b0);
    doFin(1'b1, "R8 ctx1 after ctx0 start");
  endtask

  task automatic tBlocked();
    lmax = INF;
    doStart(1'b0);
    doLeaf(1'b0, 24'h00000A, 16'd1000);
    // Leaf offered alongside a start on the other context
    @(negedge clk);
    leafValid = 1'b1; leafCtx = 1'b0; leafLabel = 24'h000001; leafMetric = 16'd5;
    startValid = 1'b1; startCtx = 1'b1;
    #1;
    check(leafReady == 1'b0, "R9 blocked by start", 64'(leafReady), 64'd0);
    @(posedge clk);
    mdlClear(1);
    @(negedge clk);
    startValid = 1'b0;
    // Leaf offered alongside a finalize
    finValid = 1'b1; finCtx = 1'b1;
    #1;
    check(leafReady == 1'b0, "R9 blocked by finalize", 64'(leafReady), 64'd0);
    @(negedge clk);
    finValid = 1'b0;
    leafValid = 1'b0;
    doFin(1'b0, "R9 blocked leaf ignored");
    check(outMetric == 16'd1000, "R9 metric untouched", 64'(outMetric), 64'd1000);
  endtask

  task automatic tMixed();
    logic [15:0] r;
    r = 16'hACE1;
    lmax = 16'd300;
    doStart(1'b0);
    doStart(1'b1);
    for (int i = 0; i < 200; i++) begin
      logic [NB-1:0] lab;
      logic [15:0] m;
      r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
      lab[15:0] = r;
      r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
      lab[23:16] = r[7:0];
      m = {4'd0, r[11:0]} + 16'd20;
      doLeaf(r[8], lab, m);
    end
    doFin(1'b0, "R2 R3 R4 mixed ctx0");
    doFin(1'b1, "R2 R3 R4 mixed ctx1");
  endtask

  initial begin
    #(5.0 * 150000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tBasic();
    tClip();
    tHard();
    tContexts();
    tBlocked();
    tMixed();
    idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule